// File: doc/BRIEF.md
# Signed PWM Audio Output Stage

This block converts 8-bit speech samples into pulse-width modulated drive for two output pins that work as a push-pull pair. Software writes a control byte and a data byte. The control byte starts and stops playback, selects single-pin or dual-pin operation, and picks one of the sample-rate settings. The data byte holds the sample.

A prescaler on the system clock paces a 7-bit duty counter, and that counter defines the carrier period. Each rate setting has its own step divider, its own carrier period length, its own repeat count and its own maximum duty.

In dual-pin mode the top data bit is a sign. It steers the 7-bit magnitude to one of the two pins and holds the other pin low. In single-pin mode the upper seven data bits are an unsigned duty that appears only on the first pin.

A new sample is taken only when a sample's repeats have finished. Stopping waits for the current carrier period to end, so no pulse is ever cut short.

Top module: `sgn_pwm_out`

## Requirements
- R1: After reset, both output pins are low, the memory power enable output is low, and the block is idle. All defined control bits reset to 0.
- R2: A control write stores the following fields:
  - bit 0: start.
  - bit 2: memory power enable, which drives `mem_pwr_en` from the cycle after the write.
  - bit 3: single-pin mode.
  - bits 6:5: rate select.
- R3: In dual-pin mode the duty is data bits 6:0. Data bit 7 = 0 drives the PWM on `pwm_p` and holds `pwm_n` low. Data bit 7 = 1 drives the PWM on `pwm_n` and holds `pwm_p` low.
- R4: In single-pin mode the duty is data bits 7:1, and it appears only on `pwm_p`. `pwm_n` stays low.
- R5: The carrier period is P counter steps, and each step lasts DIV system clocks. The active pin is high for the first d steps of each period, where d is the duty.
  - Rate 00, 01 and 11: P = 128 and d is at most 127.
  - Rate 10: P = 125, and any duty above 124 is clipped to 124.
- R6: Each sample is repeated for a whole number of carrier periods: 6 for rate 00, 5 for rate 01 and 4 for rate 10. Rate code 11 behaves as rate 00.
- R7: The data, mode and rate are latched only at a sample boundary, after the last repeat. A data write in the middle of a sample takes effect from the next sample.
- R8: When the start bit goes from 0 to 1, counting begins on the next cycle with the latched data register contents. If no new data has been written, the previous value is played again.
- R9: When the start bit goes from 1 to 0, the current carrier period completes. Then the counter stops and both pins stay low.
- R10: The two pins are never high together, and both are low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| dat_wr | input | 1 | Data register write strobe |
| dat_wdata | input | 8 | Sample write data |
| mem_pwr_en | output | 1 | Voice memory power enable from control bit 2 |
| pwm_p | output | 1 | First PWM pin (positive half, or the only pin in single-pin mode) |
| pwm_n | output | 1 | Second PWM pin (negative half) |

## Verification
The bench sweeps boundary samples and a spread of other values through every rate code in both modes. For each sample it counts the high cycles on each pin over one exact sample window.

A design with the wrong repeat count or carrier length shifts every later window and fails the counts that follow. A design that latches a mid-sample write at once corrupts the window it lands in. A design that fails to clip at rate 10, or that steers on the wrong bit, shows up directly in the counts.

Separate runs cover three further cases:
- A restart without a new data write, which must replay the old sample.
- A stop issued early in a period. If the design stops at once it cuts the pulse short; if it ignores the stop the pins keep toggling.
- Control writes, checked against the memory power output.

// File: rtl/sgn_pwm_pkg.sv
package sgn_pwm_pkg;

  localparam int CNT_W = 7;

  typedef enum logic [1:0] {
    RATE_5K  = 2'b00,
    RATE_6K  = 2'b01,
    RATE_8K  = 2'b10,
    RATE_RSV = 2'b11
  } rate_e;

  typedef struct packed {
    logic  start;
    logic  mem_pwr;
    logic  single;
    rate_e rate;
  } ctl_t;

  localparam logic [CNT_W-1:0] TOP_FULL  = 7'd127;
  localparam logic [CNT_W-1:0] TOP_SHORT = 7'd124;

  function automatic logic [CNT_W-1:0] top_of(rate_e r);
    return (r == RATE_8K) ? TOP_SHORT : TOP_FULL;
  endfunction

endpackage

// File: rtl/sgn_pwm_regs.sv
module sgn_pwm_regs
  import sgn_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output ctl_t       ctl_q,
  output logic [7:0] dat_q
);

  ctl_t       ctl_d;
  logic [7:0] dat_d;

  always_comb begin
    ctl_d = ctl_q;
    dat_d = dat_q;
    if (ctl_wr) begin
      ctl_d.start   = ctl_wdata[0];
      ctl_d.mem_pwr = ctl_wdata[2];
      ctl_d.single  = ctl_wdata[3];
      ctl_d.rate    = rate_e'(ctl_wdata[6:5]);
    end
    if (dat_wr) dat_d = dat_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '{start: 1'b0, mem_pwr: 1'b0, single: 1'b0, rate: RATE_5K};
      dat_q <= 8'h00;
    end else begin
      ctl_q <= ctl_d;
      dat_q <= dat_d;
    end
  end

  // R2: a control write lands in the stored fields on the next cycle
  a_r2_ctl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_q.start == $past(ctl_wdata[0])) && (ctl_q.single == $past(ctl_wdata[3])));

endmodule

// File: rtl/sgn_pwm_step.sv
module sgn_pwm_step
  import sgn_pwm_pkg::*;
#(
  parameter int DIV_R0 = 2,
  parameter int DIV_R1 = 2,
  parameter int DIV_R2 = 2
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  rate_e rate,
  output logic  step
);

  localparam int DIV_MAX = (DIV_R0 > DIV_R1) ? ((DIV_R0 > DIV_R2) ? DIV_R0 : DIV_R2)
                                             : ((DIV_R1 > DIV_R2) ? DIV_R1 : DIV_R2);
  localparam int PRE_W = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;

  logic [PRE_W-1:0] pre_q, pre_d, lim_m1;

  always_comb begin
    case (rate)
      RATE_6K: lim_m1 = PRE_W'(DIV_R1 - 1);
      RATE_8K: lim_m1 = PRE_W'(DIV_R2 - 1);
      default: lim_m1 = PRE_W'(DIV_R0 - 1);
    endcase
  end

  assign step = run && (pre_q == lim_m1);

  always_comb begin
    if (!run || (pre_q == lim_m1)) pre_d = '0;
    else                           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  // R5: the prescaler never runs past its per-rate limit
  a_r5_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= lim_m1);

endmodule

// File: rtl/sgn_pwm_seq.sv
module sgn_pwm_seq
  import sgn_pwm_pkg::*;
#(
  parameter int REP_R0 = 6,
  parameter int REP_R1 = 5,
  parameter int REP_R2 = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctl_t             ctl,
  input  logic [7:0]       dat,
  input  logic             step,
  output logic             run_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] duty_q,
  output logic             selb_q,
  output rate_e            rate_q
);

  localparam int REP_MAX = (REP_R0 > REP_R1) ? ((REP_R0 > REP_R2) ? REP_R0 : REP_R2)
                                             : ((REP_R1 > REP_R2) ? REP_R1 : REP_R2);
  localparam int REP_W = (REP_MAX > 1) ? $clog2(REP_MAX) : 1;

  logic [REP_W-1:0] rep_q, rep_d, rep_last;
  logic [CNT_W-1:0] cnt_d, duty_d, top, new_top, new_mag, new_duty;
  logic             run_d, selb_d, single_q, single_d, new_selb;
  rate_e            rate_d;
  logic             period_end, last_rep, load;

  assign top = top_of(rate_q);

  always_comb begin
    case (rate_q)
      RATE_6K: rep_last = REP_W'(REP_R1 - 1);
      RATE_8K: rep_last = REP_W'(REP_R2 - 1);
      default: rep_last = REP_W'(REP_R0 - 1);
    endcase
  end

  assign period_end = step && (cnt_q == top);
  assign last_rep   = (rep_q == rep_last);

  // sample to be latched from the register file
  always_comb begin
    new_top  = top_of(ctl.rate);
    new_mag  = ctl.single ? dat[7:1] : dat[6:0];
    new_selb = ctl.single ? 1'b0 : dat[7];
    new_duty = (new_mag > new_top) ? new_top : new_mag;
  end

  always_comb begin
    run_d    = run_q;
    cnt_d    = cnt_q;
    rep_d    = rep_q;
    duty_d   = duty_q;
    selb_d   = selb_q;
    single_d = single_q;
    rate_d   = rate_q;
    load     = 1'b0;
    if (!run_q) begin
      if (ctl.start) begin
        run_d = 1'b1;
        cnt_d = '0;
        rep_d = '0;
        load  = 1'b1;
      end
    end else if (step) begin
      if (period_end) begin
        cnt_d = '0;
        if (!ctl.start) begin
          run_d = 1'b0;
        end else if (last_rep) begin
          rep_d = '0;
          load  = 1'b1;
        end else begin
          rep_d = rep_q + 1'b1;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (load) begin
      rate_d   = ctl.rate;
      single_d = ctl.single;
      duty_d   = new_duty;
      selb_d   = new_selb;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cnt_q    <= '0;
      rep_q    <= '0;
      duty_q   <= '0;
      selb_q   <= 1'b0;
      single_q <= 1'b0;
      rate_q   <= RATE_5K;
    end else begin
      run_q    <= run_d;
      cnt_q    <= cnt_d;
      rep_q    <= rep_d;
      duty_q   <= duty_d;
      selb_q   <= selb_d;
      single_q <= single_d;
      rate_q   <= rate_d;
    end
  end

  // R5: counter stays within the period of the active rate
  a_r5_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= top);

  // R5: latched duty never exceeds the maximum of its rate
  a_r5_duty_clip: assert property (@(posedge clk) disable iff (!rst_n)
    duty_q <= top);

  // R6: repeat index stays below the repeat count
  a_r6_rep_range: assert property (@(posedge clk) disable iff (!rst_n)
    rep_q <= rep_last);

  // R7: no sample change except at a sample boundary
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !(period_end && last_rep)) |=> ($stable(duty_q) && $stable(selb_q)));

  // R9: playback only stops at the end of a carrier period
  a_r9_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> $past(period_end));

  // R4: single-pin mode never steers to the second pin
  a_r4_single_no_b: assert property (@(posedge clk) disable iff (!rst_n)
    single_q |-> !selb_q);

endmodule

// File: rtl/sgn_pwm_drv.sv
module sgn_pwm_drv
  import sgn_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic             selb,
  output logic             pin_p,
  output logic             pin_n
);

  logic active;

  assign active = run && (cnt < duty);
  assign pin_p  = active && !selb;
  assign pin_n  = active && selb;

  // R10: push-pull pair is never driven high on both sides
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pin_p && pin_n));

  // R10: idle block holds both pins low
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!pin_p && !pin_n));

endmodule

// File: rtl/sgn_pwm_out.sv
module sgn_pwm_out
  import sgn_pwm_pkg::*;
#(
  parameter int DIV_R0 = 2,
  parameter int DIV_R1 = 2,
  parameter int DIV_R2 = 2,
  parameter int REP_R0 = 6,
  parameter int REP_R1 = 5,
  parameter int REP_R2 = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       dat_wr,
  input  logic [7:0] dat_wdata,
  output logic       mem_pwr_en,
  output logic       pwm_p,
  output logic       pwm_n
);

  logic [1:0]       rst_sync;
  logic             rst_i;
  ctl_t             ctl_q;
  logic [7:0]       dat_q;
  logic             step, run_q, selb_q;
  logic [CNT_W-1:0] cnt_q, duty_q;
  rate_e            rate_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  sgn_pwm_regs u_regs (
    .clk(clk), .rst_n(rst_i),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata),
    .ctl_q(ctl_q), .dat_q(dat_q)
  );

  sgn_pwm_step #(.DIV_R0(DIV_R0), .DIV_R1(DIV_R1), .DIV_R2(DIV_R2)) u_step (
    .clk(clk), .rst_n(rst_i), .run(run_q), .rate(rate_q), .step(step)
  );

  sgn_pwm_seq #(.REP_R0(REP_R0), .REP_R1(REP_R1), .REP_R2(REP_R2)) u_seq (
    .clk(clk), .rst_n(rst_i), .ctl(ctl_q), .dat(dat_q), .step(step),
    .run_q(run_q), .cnt_q(cnt_q), .duty_q(duty_q), .selb_q(selb_q), .rate_q(rate_q)
  );

  sgn_pwm_drv u_drv (
    .clk(clk), .rst_n(rst_i), .run(run_q), .cnt(cnt_q), .duty(duty_q),
    .selb(selb_q), .pin_p(pwm_p), .pin_n(pwm_n)
  );

  assign mem_pwr_en = ctl_q.mem_pwr;

  // R1: nothing is driven while reset is held
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_i |-> (!pwm_p && !pwm_n && !mem_pwr_en));

endmodule

// File: tb/sgn_pwm_out_bench.sv
module sgn_pwm_out_bench;

  localparam int DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       dat_wr = 1'b0;
  logic [7:0] dat_wdata = 8'h00;
  logic       mem_pwr_en, pwm_p, pwm_n;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  sgn_pwm_out #(.DIV_R0(DIV), .DIV_R1(DIV), .DIV_R2(DIV)) u_sgn_pwm_out (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .dat_wr(dat_wr), .dat_wdata(dat_wdata), .mem_pwr_en(mem_pwr_en),
    .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int reps_of(input logic [1:0] r);
    return (r == 2'b10) ? 4 : (r == 2'b01) ? 5 : 6;
  endfunction

  function automatic int per_of(input logic [1:0] r);
    return (r == 2'b10) ? 125 : 128;
  endfunction

  function automatic int duty_of(input logic [7:0] v, input bit single, input logic [1:0] r);
    int mag, mx;
    mag = single ? int'(v[7:1]) : int'(v[6:0]);
    mx  = (r == 2'b10) ? 124 : 127;
    return (mag > mx) ? mx : mag;
  endfunction

  function automatic bit selb_of(input logic [7:0] v, input bit single);
    return single ? 1'b0 : v[7];
  endfunction

  function automatic logic [7:0] val(input int i);
    case (i)
      0: return 8'h7F;
      1: return 8'hFF;
      2: return 8'h00;
      3: return 8'h80;
      4: return 8'h7C;
      5: return 8'hFD;
      default: return 8'((i * 37 + 11) & 255);
    endcase
  endfunction

  // called at a negedge, returns at the negedge after the capturing edge
  task automatic wr_ctl(input logic [7:0] v);
    ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wr_dat(input logic [7:0] v);
    dat_wdata = v; dat_wr = 1'b1;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  // measures one sample window; writes next_v in the middle when do_wr is set
  task automatic window(input string tag, input logic [7:0] cur, input bit single,
                        input logic [1:0] r, input bit do_wr, input logic [7:0] next_v);
    int w, ca, cb, d;
    w  = reps_of(r) * per_of(r) * DIV;
    ca = 0; cb = 0;
    for (int i = 0; i < w; i++) begin
      ca += int'(pwm_p);
      cb += int'(pwm_n);
      if (do_wr && i == w / 2) begin dat_wdata = next_v; dat_wr = 1'b1; end
      if (i == w / 2 + 1) dat_wr = 1'b0;
      @(negedge clk);
    end
    d = reps_of(r) * duty_of(cur, single, r) * DIV;
    chk({tag, " pwm_p"}, ca, selb_of(cur, single) ? 0 : d);
    chk({tag, " pwm_n"}, cb, selb_of(cur, single) ? d : 0);
  endtask

  task automatic run_seq(input string tag, input bit single, input logic [1:0] r,
                         input int n);
    logic [7:0] c;
    c = {1'b0, r, 1'b0, single, 1'b1, 1'b0, 1'b1};
    wr_dat(val(0));
    wr_ctl(c);
    chk({tag, " R2 mem_pwr_en on"}, int'(mem_pwr_en), 1);
    @(negedge clk);
    for (int s = 0; s < n; s++)
      window(tag, val(s), single, r, 1'b1, val(s + 1));
    // R8: restart without a new write replays the held value
    wr_ctl(c & 8'hFE);
    repeat (per_of(r) * DIV + 4) @(negedge clk);
    wr_ctl(c);
    @(negedge clk);
    window({tag, " R8 replay"}, val(n), single, r, 1'b0, 8'h00);
    wr_ctl(c & 8'hFE);
    repeat (per_of(r) * DIV + 4) @(negedge clk);
    chk({tag, " R9 idle p"}, int'(pwm_p), 0);
    chk({tag, " R9 idle n"}, int'(pwm_n), 0);
  endtask

  task automatic stop_test(input logic [7:0] v);
    int ca, cb, late;
    wr_dat(v);
    wr_ctl(8'h01);
    @(negedge clk);
    ca = 0; cb = 0; late = 0;
    for (int i = 0; i < 3 * 128 * DIV; i++) begin
      ca += int'(pwm_p);
      cb += int'(pwm_n);
      if (i >= 128 * DIV) late += int'(pwm_p) + int'(pwm_n);
      if (i == 10) begin ctl_wdata = 8'h00; ctl_wr = 1'b1; end
      if (i == 11) ctl_wr = 1'b0;
      @(negedge clk);
    end
    chk("R9 stop p total", ca, selb_of(v, 0) ? 0 : duty_of(v, 0, 2'b00) * DIV);
    chk("R9 stop n total", cb, selb_of(v, 0) ? duty_of(v, 0, 2'b00) * DIV : 0);
    chk("R9 no pulse after period", late, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pwm_p reset", int'(pwm_p), 0);
    chk("R1 pwm_n reset", int'(pwm_n), 0);
    chk("R1 mem_pwr_en reset", int'(mem_pwr_en), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 pwm_p after release", int'(pwm_p), 0);
    chk("R1 pwm_n after release", int'(pwm_n), 0);
    // R2: bit 2 alone powers the memory without starting playback
    wr_ctl(8'h04);
    chk("R2 mem_pwr_en set", int'(mem_pwr_en), 1);
    repeat (20) @(negedge clk);
    chk("R2 no start p", int'(pwm_p), 0);
    chk("R2 no start n", int'(pwm_n), 0);
    wr_ctl(8'h00);
    chk("R2 mem_pwr_en clear", int'(mem_pwr_en), 0);
    // R3 R5 R6 R7: dual-pin sweeps per rate
    run_seq("R3 R6 R7 dual rate00", 1'b0, 2'b00, 12);
    run_seq("R3 R6 R7 dual rate01", 1'b0, 2'b01, 12);
    run_seq("R3 R5 R6 dual rate10", 1'b0, 2'b10, 12);
    run_seq("R6 dual rate11", 1'b0, 2'b11, 4);
    // R4: single-pin sweeps
    run_seq("R4 single rate00", 1'b1, 2'b00, 8);
    run_seq("R4 R5 single rate10", 1'b1, 2'b10, 6);
    // R9: stop mid-period on each pin
    stop_test(8'h40);
    stop_test(8'hC5);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule